// File: doc/BRIEF.md
# Memory copy command packet builder

This block turns one copy request into a fixed ten-word command packet. A request carries a 64-bit source offset, a 64-bit destination offset, a byte count, a row pitch and two 4-bit cache-policy indices. The block chooses one of three copy modes:

- **Page mode**, when the byte count and the low halves of both offsets are all 256-byte aligned.
- **Matrix mode**, when page mode does not apply and the pitch is above one.
- **Linear byte mode**, for everything else.

It then streams the packet out one 32-bit word per cycle on a valid/ready port. The length fields in the packet carry a minus-one bias.

Requests arrive on a valid/ready port and are taken one at a time. After accepting a request, the block runs a bit-serial division to find the row count (size over pitch) and the remainder. It then checks the encoding limits. A request that breaks a limit gives a one-cycle error pulse and no packet. A legal request loads the packet into a shift register, which drains as the consumer accepts words.

Top module: `cpy_pkt_gen`

## Requirements
- R1: A legal request yields exactly 10 words, in this order: header, width-1, rows-1, pitch-1, pitch-1, source offset bits 31:0, source offset bits 63:32, destination offset bits 31:0, destination offset bits 63:32, policy word. `pkt_last` is high only with the tenth word.
- R2: The header word is 32'h5680_0008. Bit 19 is set only in page mode, and bit 17 is set only in matrix mode.
- R3: Page mode applies when size, source offset bits 7:0 and destination offset bits 7:0 are all zero. The upper offset bits play no part. Width is size/256, and the header is 32'h5688_0008.
- R4: When page mode does not apply and pitch > 1, matrix mode is used. Width is the pitch, and the header is 32'h5682_0008.
- R5: When page mode does not apply and pitch == 1, linear mode is used. Width is the size, and the header is 32'h5680_0008.
- R6: The second length word carries size/pitch-1 in every mode.
- R7: The policy word holds the source index in bits 31:28 and the destination index in bits 6:3. All other bits are zero.
- R8: The request is rejected if any of these holds:
  - size is zero;
  - pitch is zero;
  - size is not a multiple of pitch;
  - pitch, size/pitch or width exceeds 65535.
  
  A rejected request raises `req_err` for exactly one cycle and emits no packet word.
- R9: While `pkt_valid` is high and `pkt_ready` is low, `pkt_data` and `pkt_valid` hold their values.
- R10: After reset, `req_ready` is high and `pkt_valid` and `req_err` are low. `req_ready` stays low from the accepting edge until the last packet word is taken, or until the error pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_src_addr | input | 64 | Source byte offset |
| req_dst_addr | input | 64 | Destination byte offset |
| req_size | input | SIZE_W | Byte count |
| req_pitch | input | SIZE_W | Row pitch in bytes |
| req_src_pol | input | 4 | Source cache-policy index |
| req_dst_pol | input | 4 | Destination cache-policy index |
| req_err | output | 1 | One-cycle pulse: request rejected |
| pkt_valid | output | 1 | Packet word present |
| pkt_ready | input | 1 | Consumer takes the word |
| pkt_data | output | 32 | Packet word |
| pkt_last | output | 1 | Marks the final packet word |

## Verification
The embedded properties check several things on every cycle:
- stalled output words hold steady;
- `req_ready` stays low while a packet is pending;
- the error pulse is one cycle long and never overlaps a packet;
- the serial divider's quotient and remainder reconstruct the size exactly;
- every packet opens with a well-formed header.

Only the directed scenarios can show that the right mode is chosen for each alignment case, that each field's value and order are correct, and that each limit violation is caught. The scenarios cover the mixed cases: page alignment with unaligned upper offset bits, page mode with pitch one, and a width that is too large while the row count is still legal.

// File: rtl/cpy_pkt_pkg.sv
package cpy_pkt_pkg;
  localparam int WORD_W         = 32;
  localparam int PKT_LEN        = 10;
  localparam int POL_W          = 4;
  localparam int SRC_POL_LSB    = 28;
  localparam int DST_POL_LSB    = 3;
  localparam int HDR_PAGE_BIT   = 19;
  localparam int HDR_MATRIX_BIT = 17;
  localparam logic [WORD_W-1:0] HDR_BASE = 32'h5680_0008;

  typedef enum logic [1:0] {MODE_PAGE, MODE_MATRIX, MODE_LINEAR} cpy_mode_e;
  typedef enum logic [1:0] {ST_IDLE, ST_DIV, ST_EMIT} cpy_state_e;
endpackage

// File: rtl/cpy_div.sv
module cpy_div #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         done,
  output logic [W-1:0] quot,
  output logic [W-1:0] rem
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] STEPS = CW'(W);
  localparam logic [CW-1:0] ONE_C = CW'(1);

  logic [CW-1:0] cnt;
  logic          busy;
  logic [W-1:0]  dvs;
  logic [W:0]    shifted;
  logic [W:0]    trial;

  assign shifted = {rem, quot[W-1]};
  assign trial   = shifted - {1'b0, dvs};

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      done <= 1'b0;
      cnt  <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy <= 1'b1;
        cnt  <= STEPS;
      end else if (busy) begin
        cnt <= cnt - ONE_C;
        if (cnt == ONE_C) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (start) begin
      quot <= dividend;
      rem  <= '0;
      dvs  <= divisor;
    end else if (busy) begin
      if (!trial[W]) begin
        rem  <= trial[W-1:0];
        quot <= {quot[W-2:0], 1'b1};
      end else begin
        rem  <= shifted[W-1:0];
        quot <= {quot[W-2:0], 1'b0};
      end
    end
  end

  a_r8_rem_range: assert property (@(posedge clk) disable iff (rst)
    (done && dvs != '0) |-> (rem < dvs));
endmodule

// File: rtl/cpy_mode_sel.sv
module cpy_mode_sel
  import cpy_pkt_pkg::*;
#(
  parameter int SIZE_W     = 32,
  parameter int FIELD_W    = 16,
  parameter int PAGE_SHIFT = 8
) (
  input  logic [SIZE_W-1:0] size,
  input  logic [SIZE_W-1:0] pitch,
  input  logic [SIZE_W-1:0] quot,
  input  logic [SIZE_W-1:0] rem,
  input  logic [WORD_W-1:0] src_lo,
  input  logic [WORD_W-1:0] dst_lo,
  output cpy_mode_e         mode,
  output logic [SIZE_W-1:0] width,
  output logic              bad
);
  localparam logic [SIZE_W-1:0] ONE_S = SIZE_W'(1);

  logic page_ok;
  logic fit_pitch, fit_quot, fit_width;

  assign page_ok = (size[PAGE_SHIFT-1:0] == '0) &&
                   (src_lo[PAGE_SHIFT-1:0] == '0) &&
                   (dst_lo[PAGE_SHIFT-1:0] == '0);

  always_comb begin
    if (page_ok) begin
      mode  = MODE_PAGE;
      width = size >> PAGE_SHIFT;
    end else if (pitch > ONE_S) begin
      mode  = MODE_MATRIX;
      width = pitch;
    end else begin
      mode  = MODE_LINEAR;
      width = size;
    end
  end

  assign fit_pitch = (pitch[SIZE_W-1:FIELD_W] == '0);
  assign fit_quot  = (quot[SIZE_W-1:FIELD_W] == '0);
  assign fit_width = (width[SIZE_W-1:FIELD_W] == '0);

  assign bad = (size == '0) || (pitch == '0) || (rem != '0) ||
               !fit_pitch || !fit_quot || !fit_width;
endmodule

// File: rtl/cpy_word_ser.sv
module cpy_word_ser #(
  parameter int N = 10,
  parameter int W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic [N-1:0][W-1:0] load_words,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [W-1:0]        out_data,
  output logic                out_last
);
  localparam int CW = $clog2(N + 1);
  localparam logic [CW-1:0] FULL  = CW'(N);
  localparam logic [CW-1:0] ONE_C = CW'(1);

  logic [N-1:0][W-1:0] slots;
  logic [CW-1:0]       left;
  logic                adv;

  assign adv = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (rst)       left <= '0;
    else if (load) left <= FULL;
    else if (adv)  left <= left - ONE_C;
  end

  for (genvar i = 0; i < N; i++) begin : g_slot
    if (i == N - 1) begin : g_tail
      always_ff @(posedge clk) begin
        if (load) slots[i] <= load_words[i];
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (load)     slots[i] <= load_words[i];
        else if (adv) slots[i] <= slots[i+1];
      end
    end
  end

  assign out_valid = (left != '0);
  assign out_last  = (left == ONE_C);
  assign out_data  = slots[0];

  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  a_r10_no_reload: assert property (@(posedge clk) disable iff (rst)
    load |-> !out_valid);
endmodule

// File: rtl/cpy_pkt_gen.sv
module cpy_pkt_gen
  import cpy_pkt_pkg::*;
#(
  parameter int SIZE_W     = 32,
  parameter int FIELD_W    = 16,
  parameter int PAGE_SHIFT = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [63:0]         req_src_addr,
  input  logic [63:0]         req_dst_addr,
  input  logic [SIZE_W-1:0]   req_size,
  input  logic [SIZE_W-1:0]   req_pitch,
  input  logic [3:0]          req_src_pol,
  input  logic [3:0]          req_dst_pol,
  output logic                req_err,
  output logic                pkt_valid,
  input  logic                pkt_ready,
  output logic [31:0]         pkt_data,
  output logic                pkt_last
);
  localparam int PAD_W = WORD_W - FIELD_W;
  localparam logic [FIELD_W-1:0] ONE_F = FIELD_W'(1);

  cpy_state_e state;
  logic [63:0]       c_src, c_dst;
  logic [SIZE_W-1:0] c_size, c_pitch;
  logic [3:0]        c_spol, c_dpol;

  logic              accept;
  logic              div_done;
  logic [SIZE_W-1:0] div_quot, div_rem;
  cpy_mode_e         mode;
  logic [SIZE_W-1:0] width;
  logic              bad;
  logic              ser_load;
  logic [PKT_LEN-1:0][WORD_W-1:0] words;
  logic [WORD_W-1:0] hdr, pol;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (accept) begin
      c_src   <= req_src_addr;
      c_dst   <= req_dst_addr;
      c_size  <= req_size;
      c_pitch <= req_pitch;
      c_spol  <= req_src_pol;
      c_dpol  <= req_dst_pol;
    end
  end

  cpy_div #(.W(SIZE_W)) u_div (
    .clk      (clk),
    .rst      (rst),
    .start    (accept),
    .dividend (req_size),
    .divisor  (req_pitch),
    .done     (div_done),
    .quot     (div_quot),
    .rem      (div_rem)
  );

  cpy_mode_sel #(.SIZE_W(SIZE_W), .FIELD_W(FIELD_W), .PAGE_SHIFT(PAGE_SHIFT)) u_sel (
    .size   (c_size),
    .pitch  (c_pitch),
    .quot   (div_quot),
    .rem    (div_rem),
    .src_lo (c_src[WORD_W-1:0]),
    .dst_lo (c_dst[WORD_W-1:0]),
    .mode   (mode),
    .width  (width),
    .bad    (bad)
  );

  always_comb begin
    hdr = HDR_BASE;
    hdr[HDR_PAGE_BIT]   = (mode == MODE_PAGE);
    hdr[HDR_MATRIX_BIT] = (mode == MODE_MATRIX);
    pol = '0;
    pol[SRC_POL_LSB +: POL_W] = c_spol;
    pol[DST_POL_LSB +: POL_W] = c_dpol;
    words[0] = hdr;
    words[1] = {{PAD_W{1'b0}}, width[FIELD_W-1:0] - ONE_F};
    words[2] = {{PAD_W{1'b0}}, div_quot[FIELD_W-1:0] - ONE_F};
    words[3] = {{PAD_W{1'b0}}, c_pitch[FIELD_W-1:0] - ONE_F};
    words[4] = {{PAD_W{1'b0}}, c_pitch[FIELD_W-1:0] - ONE_F};
    words[5] = c_src[WORD_W-1:0];
    words[6] = c_src[2*WORD_W-1:WORD_W];
    words[7] = c_dst[WORD_W-1:0];
    words[8] = c_dst[2*WORD_W-1:WORD_W];
    words[9] = pol;
  end

  assign ser_load = (state == ST_DIV) && div_done && !bad;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      req_err <= 1'b0;
    end else begin
      req_err <= 1'b0;
      case (state)
        ST_IDLE: if (req_valid) state <= ST_DIV;
        ST_DIV: if (div_done) begin
          if (bad) begin
            req_err <= 1'b1;
            state   <= ST_IDLE;
          end else begin
            state <= ST_EMIT;
          end
        end
        ST_EMIT: if (pkt_valid && pkt_ready && pkt_last) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  cpy_word_ser #(.N(PKT_LEN), .W(WORD_W)) u_ser (
    .clk        (clk),
    .rst        (rst),
    .load       (ser_load),
    .load_words (words),
    .out_valid  (pkt_valid),
    .out_ready  (pkt_ready),
    .out_data   (pkt_data),
    .out_last   (pkt_last)
  );

  a_r10_busy_blocks: assert property (@(posedge clk) disable iff (rst)
    pkt_valid |-> !req_ready);
  a_r8_err_no_packet: assert property (@(posedge clk) disable iff (rst)
    req_err |-> (!pkt_valid && req_ready));
  a_r8_err_single: assert property (@(posedge clk) disable iff (rst)
    req_err |=> !req_err);
  a_r6_div_exact: assert property (@(posedge clk) disable iff (rst)
    (div_done && c_pitch != '0) |->
      ((2*SIZE_W)'(div_quot) * (2*SIZE_W)'(c_pitch) + (2*SIZE_W)'(div_rem)
        == (2*SIZE_W)'(c_size)));
  a_r2_header_form: assert property (@(posedge clk) disable iff (rst)
    $rose(pkt_valid) |-> (pkt_data[31:29] == 3'b010 &&
                          !(pkt_data[HDR_PAGE_BIT] && pkt_data[HDR_MATRIX_BIT])));
  a_r1_last_valid: assert property (@(posedge clk) disable iff (rst)
    pkt_last |-> pkt_valid);
endmodule

// File: tb/tb_cpy_pkt_gen.sv
module tb_cpy_pkt_gen;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [63:0] req_src_addr = '0, req_dst_addr = '0;
  logic [31:0] req_size = '0, req_pitch = '0;
  logic [3:0]  req_src_pol = '0, req_dst_pol = '0;
  logic req_err, pkt_valid, pkt_last;
  logic pkt_ready = 1'b0;
  logic [31:0] pkt_data;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [31:0] got [10];
  logic [31:0] expw [10];
  int got_n;
  bit saw_err;
  int busy_viol, hold_viol, last_viol;

  always #2.5 clk = ~clk;

  cpy_pkt_gen dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_src_addr(req_src_addr), .req_dst_addr(req_dst_addr),
    .req_size(req_size), .req_pitch(req_pitch),
    .req_src_pol(req_src_pol), .req_dst_pol(req_dst_pol),
    .req_err(req_err), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
    .pkt_data(pkt_data), .pkt_last(pkt_last)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL R10 watchdog actual=%0d cycles expected=finish", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic build_exp(input logic [63:0] s, d, input logic [31:0] sz, p,
                           input logic [3:0] sp, dp);
    logic [31:0] w;
    if (sz[7:0] == 0 && s[7:0] == 0 && d[7:0] == 0) begin
      expw[0] = 32'h5688_0008; w = sz >> 8;
    end else if (p > 1) begin
      expw[0] = 32'h5682_0008; w = p;
    end else begin
      expw[0] = 32'h5680_0008; w = sz;
    end
    expw[1] = w - 1;
    expw[2] = sz / p - 1;
    expw[3] = p - 1;
    expw[4] = p - 1;
    expw[5] = s[31:0];
    expw[6] = s[63:32];
    expw[7] = d[31:0];
    expw[8] = d[63:32];
    expw[9] = {sp, 21'b0, dp, 3'b0};
  endtask

  task automatic run_req(input logic [63:0] s, d, input logic [31:0] sz, p,
                         input logic [3:0] sp, dp, input bit stall);
    bit prev_stall;
    logic [31:0] prev_data;
    @(negedge clk);
    req_valid = 1'b1; req_src_addr = s; req_dst_addr = d;
    req_size = sz; req_pitch = p; req_src_pol = sp; req_dst_pol = dp;
    @(negedge clk);
    req_valid = 1'b0;
    got_n = 0; saw_err = 0; busy_viol = 0; hold_viol = 0; last_viol = 0;
    prev_stall = 0; prev_data = '0;
    for (int cyc = 0; cyc < 300 && got_n < 10 && !saw_err; cyc++) begin
      pkt_ready = stall ? (cyc % 3 != 0) : 1'b1;
      #1;
      if (req_err) saw_err = 1;
      if (req_ready && !req_err) busy_viol++;
      if (prev_stall && (!pkt_valid || pkt_data != prev_data)) hold_viol++;
      if (pkt_valid && pkt_ready) begin
        got[got_n] = pkt_data;
        if (pkt_last != (got_n == 9)) last_viol++;
        got_n++;
      end
      prev_stall = pkt_valid && !pkt_ready;
      prev_data  = pkt_data;
      @(negedge clk);
    end
    pkt_ready = 1'b0;
    #1;
    chk(busy_viol == 0, "R10 ready low while busy", 64'(busy_viol), 0);
    chk(req_ready == 1'b1 && pkt_valid == 1'b0, "R10 ready after packet/error",
        {62'b0, req_ready, pkt_valid}, 64'h2);
  endtask

  task automatic check_pkt(input string wtag);
    chk(!saw_err, "R8 unexpected error", 64'(saw_err), 0);
    chk(got_n == 10, "R1 word count", 64'(got_n), 10);
    chk(last_viol == 0, "R1 last marker", 64'(last_viol), 0);
    chk(hold_viol == 0, "R9 stall hold", 64'(hold_viol), 0);
    if (got_n == 10) begin
      chk(got[0] == expw[0], "R2 header", got[0], expw[0]);
      chk(got[1] == expw[1], wtag, got[1], expw[1]);
      chk(got[2] == expw[2], "R6 rows field", got[2], expw[2]);
      for (int i = 3; i < 9; i++)
        chk(got[i] == expw[i], "R1 word order", got[i], expw[i]);
      chk(got[9] == expw[9], "R7 policy word", got[9], expw[9]);
    end
  endtask

  task automatic expect_reject(input logic [63:0] s, d, input logic [31:0] sz, p, input string tag);
    run_req(s, d, sz, p, 4'h1, 4'h2, 1'b0);
    chk(saw_err, tag, 64'(saw_err), 1);
    chk(got_n == 0, "R8 no packet on error", 64'(got_n), 0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!pkt_valid && !req_err, "R8 quiet after error", {62'b0, pkt_valid, req_err}, 0);
    end
  endtask

  task automatic t_reset;
    chk(req_ready == 1'b1, "R10 reset ready", 64'(req_ready), 1);
    chk(pkt_valid == 1'b0, "R10 reset pkt_valid", 64'(pkt_valid), 0);
    chk(req_err == 1'b0, "R10 reset req_err", 64'(req_err), 0);
  endtask

  task automatic t_page;
    build_exp(64'hABCD_0123_0001_0100, 64'h0000_0007_0000_0200, 32'h1000, 32'h100, 4'hA, 4'h5);
    chk(expw[0] == 32'h5688_0008, "R3 model page", expw[0], 32'h5688_0008);
    run_req(64'hABCD_0123_0001_0100, 64'h0000_0007_0000_0200, 32'h1000, 32'h100, 4'hA, 4'h5, 1'b0);
    check_pkt("R3 page width");
  endtask

  task automatic t_page_pitch1;
    build_exp(64'h300, 64'h0, 32'h100, 32'h1, 4'hF, 4'hF);
    run_req(64'h300, 64'h0, 32'h100, 32'h1, 4'hF, 4'hF, 1'b0);
    check_pkt("R3 page width pitch one");
  endtask

  task automatic t_matrix;
    build_exp(64'h1000, 64'h2000, 32'd300, 32'd100, 4'h3, 4'hC);
    run_req(64'h1000, 64'h2000, 32'd300, 32'd100, 4'h3, 4'hC, 1'b0);
    check_pkt("R4 matrix width");
  endtask

  task automatic t_matrix_addr;
    build_exp(64'h10, 64'h4000, 32'd512, 32'd128, 4'h0, 4'h9);
    run_req(64'h10, 64'h4000, 32'd512, 32'd128, 4'h0, 4'h9, 1'b1);
    check_pkt("R4 matrix width misaligned source");
  endtask

  task automatic t_linear;
    build_exp(64'h40, 64'h80, 32'd77, 32'd1, 4'h7, 4'h1);
    run_req(64'h40, 64'h80, 32'd77, 32'd1, 4'h7, 4'h1, 1'b0);
    check_pkt("R5 linear width");
  endtask

  task automatic t_linear_dst;
    build_exp(64'h100, 64'h1_0000_0104, 32'd256, 32'd1, 4'h2, 4'h8);
    run_req(64'h100, 64'h1_0000_0104, 32'd256, 32'd1, 4'h2, 4'h8, 1'b1);
    check_pkt("R5 linear width misaligned destination");
  endtask

  task automatic t_errors;
    expect_reject(64'h0, 64'h0, 32'd0, 32'd1, "R8 zero size");
    expect_reject(64'h0, 64'h0, 32'd64, 32'd0, "R8 zero pitch");
    expect_reject(64'h4, 64'h0, 32'd100, 32'd30, "R8 size not multiple of pitch");
    expect_reject(64'h0, 64'h0, 32'h2_0000, 32'h1_0000, "R8 pitch too wide");
    expect_reject(64'h1, 64'h0, 32'h1_0000, 32'd1, "R8 row count too large");
    expect_reject(64'h0, 64'h0, 32'h0200_0000, 32'h8000, "R8 page width too large");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    t_reset();
    t_page();
    t_page_pitch1();
    t_matrix();
    t_matrix_addr();
    t_linear();
    t_linear_dst();
    t_errors();
    t_matrix();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule